// File: doc/BRIEF.md
# Prioritised Stall Cycle Classifier

This block labels every pipeline cycle of a dual-issue streaming core as one of three categories: computation, load stall or store stall. Each cycle it looks at how many instructions issued together with a set of status flags. The flags cover outstanding load and store misses, a front-end fetch stall, a full miss-tracking table or load/store queue, a read-after-write hazard on a memory operation, an arithmetic read-after-write or structural hazard, a control hazard and a bank conflict. Several of these causes can be present in the same cycle, so a fixed priority order decides the label.

The result is used to split run time into a part that scales with core frequency (computation) and parts that do not (load and store stalls). A performance predictor can then estimate run time at a different clock. For every valid cycle the block emits a registered one-hot category pulse. It also keeps a running total per category and a total of valid cycles. These totals clear when a new kernel starts.

Top module: `cycle_class_top`

## Requirements
- R1: A valid cycle whose issue count is 2 or more is computation, whatever status flags are present.
- R2: A valid cycle that issues exactly one instruction is computation when the arithmetic hazard flag is set. Without that flag it is treated as idle and classified by R3 to R6, as is a cycle issuing zero.
- R3: An idle cycle is computation when the control hazard or bank conflict flag is set. It is also computation when load-miss-pending, store-miss-pending and fetch-stall are all clear.
- R4: For an idle cycle with a load miss pending and no control hazard or bank conflict, these checks apply in order: memory read-after-write hazard gives load stall; otherwise arithmetic hazard gives computation; otherwise queue full gives load stall; otherwise fetch stall gives load stall.
- R5: An idle cycle with a load miss pending that matches none of the R4 checks is computation.
- R6: An idle cycle with no load miss pending is a store stall when queue full is set and either store-miss-pending or fetch-stall is set. In every other such case it is computation.
- R7: Category pulses appear on the clock edge that samples a valid cycle and last one cycle. Exactly one of them is high after a valid cycle, and none is high after an invalid cycle.
- R8: Each category total counts the valid cycles of that category. The cycle total counts all valid cycles. The three category totals always sum to the cycle total, modulo the counter width.
- R9: A synchronous kernel-start input clears all totals and pulses at the next edge. The cycle presented together with it is not counted.
- R10: After synchronous reset, all pulses and totals are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| kstart | input | 1 | Kernel start; clears totals and pulses |
| valid | input | 1 | The current cycle is to be classified |
| issue_cnt | input | ISSUE_W | Instructions issued this cycle |
| ld_pend | input | 1 | At least one load miss outstanding |
| st_pend | input | 1 | At least one store miss outstanding |
| fetch_stall | input | 1 | Front end stalled on an instruction fetch |
| queue_full | input | 1 | Miss-tracking table or load/store queue full |
| mem_raw | input | 1 | Read-after-write hazard on a memory operation |
| alu_haz | input | 1 | Arithmetic read-after-write or structural hazard |
| ctrl_haz | input | 1 | Control hazard |
| bank_conf | input | 1 | Register or memory bank conflict |
| comp_pulse | output | 1 | Previous valid cycle was computation |
| ld_pulse | output | 1 | Previous valid cycle was a load stall |
| st_pulse | output | 1 | Previous valid cycle was a store stall |
| comp_total | output | CNT_W | Computation cycles since kernel start |
| ld_total | output | CNT_W | Load-stall cycles since kernel start |
| st_total | output | CNT_W | Store-stall cycles since kernel start |
| cyc_total | output | CNT_W | Valid cycles since kernel start |

## Verification
Inputs presented before a rising edge produce their category pulse right after that edge. The totals include that cycle on the same edge, so every result is due exactly one edge after its stimulus. The bench changes inputs on the falling edge. At the following falling edge it compares pulses and totals against a behavioural model that was advanced when those inputs were driven. This lands every comparison half a cycle after the edge on which the result becomes due.

// File: rtl/stall_cls_pkg.sv
package stall_cls_pkg;

    typedef enum logic [1:0] {
        CAT_COMP  = 2'd0,
        CAT_LOAD  = 2'd1,
        CAT_STORE = 2'd2
    } cat_e;

    localparam int NUM_CAT = 3;

    typedef struct packed {
        logic ld_pend;
        logic st_pend;
        logic fetch_stall;
        logic queue_full;
        logic mem_raw;
        logic alu_haz;
        logic ctrl_haz;
        logic bank_conf;
    } cause_t;

    // Fixed-priority labelling of one pipeline cycle.
    function automatic cat_e pick_category(input int unsigned issued,
                                           input int unsigned max_issue,
                                           input cause_t c);
        cat_e r;
        r = CAT_COMP;
        if (issued >= max_issue) begin
            r = CAT_COMP;
        end else if (issued != 0 && c.alu_haz) begin
            r = CAT_COMP;
        end else if (c.ctrl_haz || c.bank_conf) begin
            r = CAT_COMP;
        end else if (!c.ld_pend && !c.st_pend && !c.fetch_stall) begin
            r = CAT_COMP;
        end else if (c.ld_pend) begin
            if (c.mem_raw)          r = CAT_LOAD;
            else if (c.alu_haz)     r = CAT_COMP;
            else if (c.queue_full)  r = CAT_LOAD;
            else if (c.fetch_stall) r = CAT_LOAD;
            else                    r = CAT_COMP;
        end else if (c.queue_full) begin
            r = CAT_STORE;
        end
        return r;
    endfunction

endpackage

// File: rtl/cause_decoder.sv
module cause_decoder
    import stall_cls_pkg::*;
#(
    parameter int ISSUE_MAX = 2,
    parameter int ISSUE_W   = 2
) (
    input  logic [ISSUE_W-1:0] issue_cnt,
    input  cause_t             cause,
    output logic [NUM_CAT-1:0] onehot
);
    cat_e sel;

    always_comb begin
        sel    = pick_category(int'(issue_cnt), ISSUE_MAX, cause);
        onehot = '0;
        onehot[sel] = 1'b1;
    end
endmodule

// File: rtl/pulse_stage.sv
module pulse_stage
    import stall_cls_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               kstart,
    input  logic               valid,
    input  logic [NUM_CAT-1:0] onehot_in,
    output logic [NUM_CAT-1:0] pulses
);
    always_ff @(posedge clk) begin
        if (rst || kstart)  pulses <= '0;
        else if (valid)     pulses <= onehot_in;
        else                pulses <= '0;
    end

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        (valid && !kstart) |=> ($countones(pulses) == 1)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!valid) |=> (pulses == '0)); // R7
endmodule

// File: rtl/cat_counter.sv
module cat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end
endmodule

// File: rtl/cycle_class_top.sv
module cycle_class_top
    import stall_cls_pkg::*;
#(
    parameter  int ISSUE_MAX = 2,
    parameter  int CNT_W     = 32,
    localparam int ISSUE_W   = $clog2(ISSUE_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               kstart,
    input  logic               valid,
    input  logic [ISSUE_W-1:0] issue_cnt,
    input  logic               ld_pend,
    input  logic               st_pend,
    input  logic               fetch_stall,
    input  logic               queue_full,
    input  logic               mem_raw,
    input  logic               alu_haz,
    input  logic               ctrl_haz,
    input  logic               bank_conf,
    output logic               comp_pulse,
    output logic               ld_pulse,
    output logic               st_pulse,
    output logic [CNT_W-1:0]   comp_total,
    output logic [CNT_W-1:0]   ld_total,
    output logic [CNT_W-1:0]   st_total,
    output logic [CNT_W-1:0]   cyc_total
);
    cause_t             cause;
    logic [NUM_CAT-1:0] onehot;
    logic [NUM_CAT-1:0] pulses;
    logic [CNT_W-1:0]   totals [NUM_CAT];
    logic               count_en;

    assign cause = '{ld_pend: ld_pend, st_pend: st_pend, fetch_stall: fetch_stall,
                     queue_full: queue_full, mem_raw: mem_raw, alu_haz: alu_haz,
                     ctrl_haz: ctrl_haz, bank_conf: bank_conf};
    assign count_en = valid && !kstart;

    cause_decoder #(.ISSUE_MAX(ISSUE_MAX), .ISSUE_W(ISSUE_W)) u_dec (
        .issue_cnt (issue_cnt),
        .cause     (cause),
        .onehot    (onehot)
    );

    pulse_stage u_pulse (
        .clk       (clk),
        .rst       (rst),
        .kstart    (kstart),
        .valid     (valid),
        .onehot_in (onehot),
        .pulses    (pulses)
    );

    for (genvar i = 0; i < NUM_CAT; i++) begin : g_cat
        cat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (kstart),
            .inc   (count_en && onehot[i]),
            .count (totals[i])
        );
    end

    cat_counter #(.CNT_W(CNT_W)) u_cyc (
        .clk   (clk),
        .rst   (rst),
        .clr   (kstart),
        .inc   (count_en),
        .count (cyc_total)
    );

    assign comp_pulse = pulses[CAT_COMP];
    assign ld_pulse   = pulses[CAT_LOAD];
    assign st_pulse   = pulses[CAT_STORE];
    assign comp_total = totals[CAT_COMP];
    assign ld_total   = totals[CAT_LOAD];
    assign st_total   = totals[CAT_STORE];

    AST_FULL_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (count_en && int'(issue_cnt) >= ISSUE_MAX) |=> comp_pulse); // R1
    AST_STORE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (count_en && ld_pend) |=> !st_pulse); // R6
    AST_TOTAL_SUM: assert property (@(posedge clk) disable iff (rst)
        cyc_total == comp_total + ld_total + st_total); // R8
    AST_KSTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        kstart |=> (cyc_total == '0 && comp_total == '0 && ld_total == '0
                    && st_total == '0 && pulses == '0)); // R9
endmodule

// File: tb/sim_cycle_class_top.sv
module sim_cycle_class_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst, kstart, valid;
    logic [1:0]  issue_cnt;
    logic        ld_pend, st_pend, fetch_stall, queue_full;
    logic        mem_raw, alu_haz, ctrl_haz, bank_conf;
    logic        comp_pulse, ld_pulse, st_pulse;
    logic [31:0] comp_total, ld_total, st_total, cyc_total;

    cycle_class_top u0 (
        .clk(clk), .rst(rst), .kstart(kstart), .valid(valid), .issue_cnt(issue_cnt),
        .ld_pend(ld_pend), .st_pend(st_pend), .fetch_stall(fetch_stall),
        .queue_full(queue_full), .mem_raw(mem_raw), .alu_haz(alu_haz),
        .ctrl_haz(ctrl_haz), .bank_conf(bank_conf),
        .comp_pulse(comp_pulse), .ld_pulse(ld_pulse), .st_pulse(st_pulse),
        .comp_total(comp_total), .ld_total(ld_total), .st_total(st_total),
        .cyc_total(cyc_total)
    );

    int          checks = 0;
    int          errors = 0;
    logic [2:0]  exp_p = 3'b000;   // {store, load, comp}
    logic [31:0] exp_c = 0, exp_l = 0, exp_s = 0, exp_y = 0;
    string       cur_tag = "R10";

    // Bench-side flag vector, bit 7 down to 0:
    // load pending, store pending, fetch stall, queue full, mem RAW, alu hazard, ctrl hazard, bank conflict
    function automatic int ref_cat(input int iss, input logic [7:0] f);
        logic ld = f[7], st = f[6], fe = f[5], qf = f[4];
        logic mr = f[3], ah = f[2], ch = f[1], bc = f[0];
        if (iss >= 2) return 0;
        if (iss == 1 && ah) return 0;
        if (ch || bc) return 0;
        if (ld) begin
            if (mr) return 1;
            if (ah) return 0;
            if (qf || fe) return 1;
            return 0;
        end
        if (qf && (st || fe)) return 2;
        return 0;
    endfunction

    task automatic cmp32(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
        end
    endtask

    task automatic check_now();
        checks++;
        if ({st_pulse, ld_pulse, comp_pulse} !== exp_p) begin
            errors++;
            $display("FAIL %s pulses actual=%b expected=%b", cur_tag,
                     {st_pulse, ld_pulse, comp_pulse}, exp_p);
        end
        cmp32("comp_total", comp_total, exp_c);
        cmp32("ld_total", ld_total, exp_l);
        cmp32("st_total", st_total, exp_s);
        cmp32("cyc_total", cyc_total, exp_y);
    endtask

    task automatic drive(input logic r, input logic ks, input logic v, input int iss,
                         input logic [7:0] f, input string tag);
        @(negedge clk);
        check_now();
        rst = r; kstart = ks; valid = v; issue_cnt = 2'(iss);
        {ld_pend, st_pend, fetch_stall, queue_full, mem_raw, alu_haz, ctrl_haz, bank_conf} = f;
        cur_tag = tag;
        if (r || ks) begin
            exp_p = 3'b000; exp_c = 0; exp_l = 0; exp_s = 0; exp_y = 0;
        end else if (!v) begin
            exp_p = 3'b000;
        end else begin
            int k = ref_cat(iss, f);
            exp_p = 3'b001 << k;
            exp_y++;
            if (k == 0) exp_c++;
            else if (k == 1) exp_l++;
            else exp_s++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; kstart = 0; valid = 0; issue_cnt = 0;
        {ld_pend, st_pend, fetch_stall, queue_full, mem_raw, alu_haz, ctrl_haz, bank_conf} = '0;
        // R10: reset state
        drive(1, 0, 0, 0, 8'h00, "R10");
        drive(1, 0, 1, 2, 8'hFF, "R10");
        drive(0, 0, 0, 0, 8'h00, "R10");
        // R1: full issue beats every stall cause
        drive(0, 0, 1, 2, 8'b1001_1000, "R1");
        drive(0, 0, 1, 3, 8'b0101_0000, "R1");
        // R2: single issue
        drive(0, 0, 1, 1, 8'b1000_1100, "R2");
        drive(0, 0, 1, 1, 8'b1000_1000, "R2");
        drive(0, 0, 1, 1, 8'b0101_0000, "R2");
        // R3: control / bank / nothing pending
        drive(0, 0, 1, 0, 8'b1000_1010, "R3");
        drive(0, 0, 1, 0, 8'b0101_0001, "R3");
        drive(0, 0, 1, 0, 8'b0001_1100, "R3");
        // R4: ordered load checks
        drive(0, 0, 1, 0, 8'b1011_1100, "R4");
        drive(0, 0, 1, 0, 8'b1011_0100, "R4");
        drive(0, 0, 1, 0, 8'b1001_0000, "R4");
        drive(0, 0, 1, 0, 8'b1010_0000, "R4");
        // R5: load pending, no matching check
        drive(0, 0, 1, 0, 8'b1000_0000, "R5");
        drive(0, 0, 1, 0, 8'b1100_0000, "R5");
        // R6: store stall path
        drive(0, 0, 1, 0, 8'b0101_0000, "R6");
        drive(0, 0, 1, 0, 8'b0011_0000, "R6");
        drive(0, 0, 1, 0, 8'b0100_0000, "R6");
        drive(0, 0, 1, 0, 8'b0001_0100, "R6");
        // R7: invalid cycles produce nothing and hold totals
        drive(0, 0, 0, 0, 8'b1001_0000, "R7");
        drive(0, 0, 0, 2, 8'b0101_0000, "R7");
        // R9: kernel start clears, its cycle not counted
        drive(0, 1, 1, 0, 8'b1001_0000, "R9");
        drive(0, 0, 1, 0, 8'b0101_0000, "R9");
        // R8: mixed traffic, totals and sum tracked every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] f = 8'($urandom);
            logic ks = ($urandom % 97) == 0;
            logic v = ($urandom % 8) != 0;
            drive(0, ks, v, int'($urandom % 4), f, "R8");
        end
        drive(0, 0, 0, 0, 8'h00, "R8");
        @(negedge clk);
        check_now();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule